// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit down-counting timer channel. It advances only on cycles where the `tick` clock enable is high, and it has six operating modes. A single-cycle load strobe delivers a new initial count, a 3-bit mode number and a binary/decimal select. The channel then produces the present count and an OUT waveform whose shape depends on the mode:

- Mode 0 raises a flag on terminal count.
- Mode 1 is a one-shot that a gate edge can retrigger.
- Mode 2 is a rate generator.
- Mode 3 is a square wave.
- Modes 4 and 5 give a single strobe, started by software or by the gate.

Bus decoding, count latching and read-back sit in a neighbouring block, which samples `count_out` and `out_o` directly. In decimal mode every nibble holds one digit, 0 to 9. An initial count of zero selects the full range of the chosen number system.

Top module: `pit_channel`

## Requirements
- R1: After reset `count_out` is 0 and `out_o` is 0. Ticks and gate activity have no effect until the first load strobe.
- R2: A load strobe takes effect at the next clock edge and has priority over everything else. The mode field is folded so that values 6 and 7 act as modes 2 and 3. In the cycle after the load, `count_out` equals the initial count, or in mode 3 the initial count rounded up to the next even value. `out_o` is 1 in mode 3 and 0 in every other mode.
- R3: An initial count of 0 behaves as 65536 ticks in binary and as 10000 ticks in decimal.
- R4: In modes 0, 1, 4 and 5 the counter does not stop at zero. It wraps to 16'hFFFF in binary or 16'h9999 in decimal and keeps decrementing.
- R5: In decimal mode (`load_bcd`=1) each nibble counts down from 9 to 0 and borrows from the next nibble. In binary mode the counter is a plain 16-bit decrement.
- R6: In modes 0, 2, 3 and 4 the channel counts only while `gate` is 1. In modes 1 and 5 it counts whatever the gate level. A 0-to-1 edge on `gate` reloads the initial count in modes 1, 2, 3 and 5, one clock after the edge. In modes 0 and 4 the edge does not reload.
- R7: In mode 0, `out_o` goes to 1 on the tick that brings the count to zero, and it stays 1 until the next load.
- R8: In mode 1, `out_o` is 0 while the elapsed ticks are below the count. It goes to 1 on the tick that reaches the count and stays 1 until a retrigger or a load.
- R9: In mode 2, on the tick where the elapsed ticks reach a multiple of the count, the counter reloads and `out_o` becomes 1. `out_o` returns to 0 on the following tick. The count never shows 0 in this mode.
- R10: In mode 3 the counter steps down by two per tick. `out_o` is 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks of each period N, for N of at least 2.
- R11: In modes 4 and 5, `out_o` is 1 for exactly one tick, starting on the tick where the elapsed ticks equal the count. It does not pulse again after a wrap until the next load, or in mode 5 a retrigger.
- R12: `count_out` and `out_o` change only at a clock edge that has a tick, a load strobe or a retriggering gate edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one count step per high cycle |
| gate | input | 1 | Gate level; counting enable or retrigger source |
| load | input | 1 | Single-cycle strobe that takes the three load fields |
| load_count | input | 16 | Initial count (0 selects the full range) |
| load_mode | input | 3 | Mode number; 6 and 7 fold to 2 and 3 |
| load_bcd | input | 1 | 1 selects four-digit decimal counting |
| count_out | output | 16 | Present counter value |
| out_o | output | 1 | Timer output waveform |

## Verification
Most faults in the counter state appear on `count_out` at the first tick after they arise. A wrong reload value in mode 2 or 3 only becomes visible at the end of the period, so the bench checks on both sides of every reload. A corrupted armed flag or phase bit is invisible until the next terminal event. There it shows as a repeated strobe after a wrap, or as an inverted half-period in mode 3. For that reason the bench runs a decimal channel through a complete 10000-tick wrap.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W = 16;
  localparam int DIG_W = 4;
  localparam int N_DIG = CNT_W / DIG_W;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    M_TERM   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } mode_e;

  // 6 and 7 alias the periodic modes
  function automatic mode_e fold_mode(input logic [2:0] f);
    if (f[2] && f[1]) return mode_e'({1'b0, f[1:0]});
    return mode_e'(f);
  endfunction

  function automatic cnt_t step_down(input cnt_t v, input logic dec);
    cnt_t r;
    logic borrow;
    if (!dec) return v - cnt_t'(1);
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < N_DIG; i++) begin
      if (borrow) begin
        if (v[DIG_W*i +: DIG_W] == '0) begin
          r[DIG_W*i +: DIG_W] = DIG_W'(9);
        end else begin
          r[DIG_W*i +: DIG_W] = v[DIG_W*i +: DIG_W] - DIG_W'(1);
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic cnt_t step_up(input cnt_t v, input logic dec);
    cnt_t r;
    logic carry;
    if (!dec) return v + cnt_t'(1);
    r = v;
    carry = 1'b1;
    for (int i = 0; i < N_DIG; i++) begin
      if (carry) begin
        if (v[DIG_W*i +: DIG_W] == DIG_W'(9)) begin
          r[DIG_W*i +: DIG_W] = '0;
        end else begin
          r[DIG_W*i +: DIG_W] = v[DIG_W*i +: DIG_W] + DIG_W'(1);
          carry = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // square wave: high phase start rounds odd counts up, low phase down
  function automatic cnt_t hi_start(input cnt_t v, input logic dec);
    return v[0] ? step_up(v, dec) : v;
  endfunction

  function automatic cnt_t lo_start(input cnt_t v, input logic dec);
    return v[0] ? step_down(v, dec) : v;
  endfunction

  function automatic logic free_running(input mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  function automatic logic edge_restarts(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction
endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  cnt_t  ld_val,
  input  mode_e ld_mode,
  input  logic  ld_bcd,
  input  logic  retrig,
  input  cnt_t  init,
  input  mode_e mode,
  input  logic  bcd,
  input  logic  run,
  input  logic  phase_hi,
  output cnt_t  cnt,
  output logic  term
);
  cnt_t nxt;

  always_comb begin
    nxt = step_down(cnt, bcd);
    if (mode == M_SQUARE) nxt = step_down(nxt, bcd);
    term = run && (nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (ld_mode == M_SQUARE) ? hi_start(ld_val, ld_bcd) : ld_val;
    end else if (retrig) begin
      cnt <= (mode == M_SQUARE) ? hi_start(init, bcd) : init;
    end else if (run) begin
      if (term && mode == M_RATE)
        cnt <= init;
      else if (term && mode == M_SQUARE)
        cnt <= phase_hi ? lo_start(init, bcd) : hi_start(init, bcd);
      else
        cnt <= nxt;
    end
  end

  // R12: no step without a cause
  a_r12_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !retrig && !run) |=> $stable(cnt));

  // R4: one-shot style modes wrap from zero to the top of the range
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !retrig && cnt == '0 &&
     (mode == M_TERM || mode == M_ONESHOT || mode == M_SWSTB || mode == M_HWSTB))
    |=> (cnt == (bcd ? cnt_t'(16'h9999) : cnt_t'(16'hFFFF))));
endmodule

// File: rtl/pit_out_gen.sv
module pit_out_gen
  import pit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_e ld_mode,
  input  logic  retrig,
  input  mode_e mode,
  input  logic  tick_act,
  input  logic  term,
  output logic  out
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out   <= 1'b0;
      armed <= 1'b0;
    end else if (load) begin
      out   <= (ld_mode == M_SQUARE);
      armed <= 1'b1;
    end else if (retrig) begin
      out   <= (mode == M_SQUARE);
      armed <= 1'b1;
    end else if (tick_act) begin
      if (mode == M_RATE || mode == M_SWSTB || mode == M_HWSTB) out <= 1'b0;
      if (term) begin
        case (mode)
          M_TERM, M_ONESHOT, M_RATE: out <= 1'b1;
          M_SQUARE: out <= ~out;
          default: begin
            if (armed) begin
              out   <= 1'b1;
              armed <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  // R7: terminal flag holds until reload
  a_r7_term_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TERM && out && !load) |=> out);

  // R8: one-shot output stays high until retrigger or load
  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ONESHOT && out && !load && !retrig) |=> out);

  // R11: strobe lasts a single tick
  a_r11_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_SWSTB || mode == M_HWSTB) && out && tick_act && !load) |=> !out);

  // R12: output moves only on an event
  a_r12_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !retrig && !tick_act) |=> $stable(out));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             load,
  input  logic [CNT_W-1:0] load_count,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  output logic [CNT_W-1:0] count_out,
  output logic             out_o
);
  logic  active;
  mode_e mode_r;
  logic  bcd_r;
  cnt_t  init_r;

  mode_e ld_mode;
  logic  gate_rise;
  logic  retrig;
  logic  tick_act;
  logic  run;
  logic  term;

  assign ld_mode  = fold_mode(load_mode);
  assign retrig   = active && gate_rise && edge_restarts(mode_r) && !load;
  assign tick_act = active && tick && !load && !retrig;
  assign run      = tick_act && (gate || free_running(mode_r));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_r <= M_TERM;
      bcd_r  <= 1'b0;
      init_r <= '0;
    end else if (load) begin
      active <= 1'b1;
      mode_r <= ld_mode;
      bcd_r  <= load_bcd;
      init_r <= load_count;
    end
  end

  pit_gate_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .gate (gate),
    .rise (gate_rise)
  );

  pit_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ld_val  (load_count),
    .ld_mode (ld_mode),
    .ld_bcd  (load_bcd),
    .retrig  (retrig),
    .init    (init_r),
    .mode    (mode_r),
    .bcd     (bcd_r),
    .run     (run),
    .phase_hi(out_o),
    .cnt     (count_out),
    .term    (term)
  );

  pit_out_gen u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ld_mode (ld_mode),
    .retrig  (retrig),
    .mode    (mode_r),
    .tick_act(tick_act),
    .term    (term),
    .out     (out_o)
  );

  // R1: idle channel shows nothing
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (count_out == '0 && !out_o));

  // R6: gated modes hold while gate is low
  a_r6_gate_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !gate && !free_running(mode_r) && !load) |=> $stable(count_out));
endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_count = '0;
  logic [2:0]  load_mode = '0;
  logic        load_bcd = 1'b0;
  logic [15:0] count_out;
  logic        out_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pit_channel uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
    .load_count(load_count), .load_mode(load_mode), .load_bcd(load_bcd),
    .count_out(count_out), .out_o(out_o)
  );

  // fields: mode[63:61] bcd[60] N[59:44] ticks[43:28] exp_cnt[27:12] exp_out[11] req[10:3]
  localparam int NV = 25;
  localparam logic [63:0] TBL [NV] = '{
    {3'd0, 1'b0, 16'h0005, 16'd3,     16'h0002, 1'b0, 8'd7,  3'd0}, // R7 before terminal
    {3'd0, 1'b0, 16'h0005, 16'd5,     16'h0000, 1'b1, 8'd7,  3'd0}, // R7 at terminal
    {3'd0, 1'b0, 16'h0005, 16'd7,     16'hFFFE, 1'b1, 8'd4,  3'd0}, // R4 binary wrap
    {3'd0, 1'b1, 16'h0003, 16'd4,     16'h9999, 1'b1, 8'd4,  3'd0}, // R4 decimal wrap
    {3'd0, 1'b1, 16'h0100, 16'd1,     16'h0099, 1'b0, 8'd5,  3'd0}, // R5 double borrow
    {3'd0, 1'b0, 16'h0000, 16'd1,     16'hFFFF, 1'b0, 8'd3,  3'd0}, // R3 full binary
    {3'd2, 1'b0, 16'h0004, 16'd4,     16'h0004, 1'b1, 8'd9,  3'd0}, // R9 reload pulse
    {3'd2, 1'b0, 16'h0004, 16'd5,     16'h0003, 1'b0, 8'd9,  3'd0}, // R9 pulse ends
    {3'd3, 1'b0, 16'h0005, 16'd2,     16'h0002, 1'b1, 8'd10, 3'd0}, // R10 odd high
    {3'd3, 1'b0, 16'h0005, 16'd3,     16'h0004, 1'b0, 8'd10, 3'd0}, // R10 odd low
    {3'd3, 1'b0, 16'h0005, 16'd5,     16'h0006, 1'b1, 8'd10, 3'd0}, // R10 new period
    {3'd3, 1'b0, 16'h0006, 16'd3,     16'h0006, 1'b0, 8'd10, 3'd0}, // R10 even half
    {3'd4, 1'b0, 16'h0003, 16'd3,     16'h0000, 1'b1, 8'd11, 3'd0}, // R11 strobe
    {3'd4, 1'b0, 16'h0003, 16'd4,     16'hFFFF, 1'b0, 8'd11, 3'd0}, // R11 strobe ends
    {3'd5, 1'b0, 16'h0003, 16'd3,     16'h0000, 1'b1, 8'd11, 3'd0}, // R11 gate-started strobe
    {3'd6, 1'b0, 16'h0004, 16'd4,     16'h0004, 1'b1, 8'd2,  3'd0}, // R2 fold 6
    {3'd7, 1'b0, 16'h0005, 16'd3,     16'h0004, 1'b0, 8'd2,  3'd0}, // R2 fold 7
    {3'd1, 1'b0, 16'h0003, 16'd2,     16'h0001, 1'b0, 8'd8,  3'd0}, // R8 below count
    {3'd1, 1'b0, 16'h0003, 16'd3,     16'h0000, 1'b1, 8'd8,  3'd0}, // R8 reached
    {3'd2, 1'b1, 16'h0010, 16'd10,    16'h0010, 1'b1, 8'd5,  3'd0}, // R5 decimal reload
    {3'd2, 1'b1, 16'h0010, 16'd1,     16'h0009, 1'b0, 8'd5,  3'd0}, // R5 tens borrow
    {3'd3, 1'b1, 16'h0000, 16'd1,     16'h9998, 1'b1, 8'd3,  3'd0}, // R3 decimal square
    {3'd2, 1'b1, 16'h0000, 16'd10000, 16'h0000, 1'b1, 8'd3,  3'd0}, // R3 10000 period
    {3'd3, 1'b1, 16'h0000, 16'd5000,  16'h0000, 1'b0, 8'd3,  3'd0}, // R3 half of 10000
    {3'd0, 1'b1, 16'h0000, 16'd2,     16'h9998, 1'b0, 8'd5,  3'd0}  // R5 from zero
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] n);
    @(negedge clk);
    load = 1'b1; load_mode = m; load_bcd = b; load_count = n;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk) gate = g;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", count_out, 16'h0);
    chk("R1 reset out", {15'b0, out_o}, 16'h0);
    set_gate(1'b1);
    do_ticks(3);
    set_gate(1'b0);
    set_gate(1'b1);
    do_ticks(2);
    chk("R1 idle count", count_out, 16'h0);
    chk("R1 idle out", {15'b0, out_o}, 16'h0);

    // table walk, gate held high
    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = TBL[i];
      do_load(v[63:61], v[60], v[59:44]);
      do_ticks(int'(v[43:28]));
      chk($sformatf("R%0d row %0d count", v[10:3], i), count_out, v[27:12]);
      chk($sformatf("R%0d row %0d out", v[10:3], i), {15'b0, out_o}, {15'b0, v[11]});
    end

    // R2 immediate load state
    do_load(3'd0, 1'b0, 16'h1234);
    chk("R2 load count", count_out, 16'h1234);
    chk("R2 load out", {15'b0, out_o}, 16'h0);
    do_load(3'd3, 1'b0, 16'h0005);
    chk("R2 square load count", count_out, 16'h0006);
    chk("R2 square load out", {15'b0, out_o}, 16'h1);

    // R12 no tick, no change
    do_load(3'd0, 1'b0, 16'h0009);
    repeat (5) @(negedge clk);
    chk("R12 stable without tick", count_out, 16'h0009);

    // R6 mode 0 pause, no retrigger
    do_load(3'd0, 1'b0, 16'h0005);
    do_ticks(2);
    set_gate(1'b0);
    do_ticks(3);
    chk("R6 mode0 paused", count_out, 16'h0003);
    set_gate(1'b1);
    @(negedge clk);
    chk("R6 mode0 edge ignored", count_out, 16'h0003);
    do_ticks(1);
    chk("R6 mode0 resumes", count_out, 16'h0002);

    // R6/R8 mode 1 free-running and retrigger
    do_load(3'd1, 1'b0, 16'h0004);
    do_ticks(3);
    set_gate(1'b0);
    do_ticks(2);
    chk("R6 mode1 counts gate low", count_out, 16'hFFFF);
    chk("R8 mode1 out high", {15'b0, out_o}, 16'h1);
    set_gate(1'b1);
    @(negedge clk);
    chk("R6 mode1 retrigger count", count_out, 16'h0004);
    chk("R8 mode1 retrigger out", {15'b0, out_o}, 16'h0);
    do_ticks(4);
    chk("R8 mode1 second shot", {15'b0, out_o}, 16'h1);

    // R6 mode 2 pause and retrigger
    do_load(3'd2, 1'b0, 16'h0004);
    do_ticks(2);
    set_gate(1'b0);
    do_ticks(1);
    chk("R6 mode2 paused", count_out, 16'h0002);
    set_gate(1'b1);
    @(negedge clk);
    chk("R6 mode2 retrigger", count_out, 16'h0004);

    // R11 mode 4 one strobe across a decimal wrap
    do_load(3'd4, 1'b1, 16'h0002);
    do_ticks(2);
    chk("R11 mode4 strobe", {15'b0, out_o}, 16'h1);
    do_ticks(10000);
    chk("R11 mode4 wrap count", count_out, 16'h0000);
    chk("R11 mode4 no second strobe", {15'b0, out_o}, 16'h0);

    // R11 mode 5 rearm on gate edge
    do_load(3'd5, 1'b0, 16'h0003);
    do_ticks(4);
    chk("R11 mode5 after strobe", {15'b0, out_o}, 16'h0);
    set_gate(1'b0);
    set_gate(1'b1);
    @(negedge clk);
    chk("R6 mode5 retrigger", count_out, 16'h0003);
    do_ticks(3);
    chk("R11 mode5 rearmed strobe", {15'b0, out_o}, 16'h1);

    // R2 load overrides a running count
    do_load(3'd2, 1'b0, 16'h0008);
    do_ticks(3);
    do_load(3'd2, 1'b0, 16'h0020);
    chk("R2 reload mid-count", count_out, 16'h0020);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule